// File: doc/BRIEF.md
# System Board Control Port Decoder

This block is a small set of 8-bit I/O-mapped registers for a legacy PC system board. A host drives a synchronous I/O bus with a 16-bit address, 8-bit write data and separate read and write strobes. The block decodes the full address, stores what is written to its ports and returns read data combinationally. It also turns a few stored fields into control outputs for the rest of the board.

Port 0x92 carries the alternate A20 gate and a self-clearing soft CPU reset bit. Port 0x102 packs the serial port enable, the parallel port enable and a 2-bit parallel base select. The block decodes that field into clean enable and select outputs, so the controllers downstream never see the reserved select code. Port 0x91 is a read-only zero port, and port 0x105 reads back with its top bit forced high. Ports 0x94, 0x103, 0x104 and 0x190 are plain scratch storage. The serial and parallel controllers and the memory map sit outside this block.

Top module: `sysbrd_ctl_ports`

## Requirements
- R1: After reset, `a20_en_o`, `cpu_rst_o` and `ser_en_o` are 0, `par_en_o` is 1 with `par_base_o` = 0, ports 0x94/0x103/0x104/0x190 read 0x00, port 0x102 reads 0x10 and port 0x105 reads 0x80.
- R2: `a20_en_o` follows bit 1 of the last value written to port 0x92, from the cycle after the write. A read of 0x92 returns the written value with bit 0 cleared.
- R3: A write to port 0x92 with bit 0 = 1 drives `cpu_rst_o` high for exactly the one cycle after the write. A write with bit 0 = 0 produces no pulse.
- R4: `ser_en_o` equals bit 2 of the last value written to port 0x102.
- R5: From port 0x102, when bit 4 = 1 and bits 6:5 hold 0, 1 or 2, `par_en_o` = 1 and `par_base_o` equals bits 6:5. The codes mean 0 = 0x3BC, 1 = 0x378 and 2 = 0x278. When bit 4 = 0, or bits 6:5 = 3, `par_en_o` = 0 and `par_base_o` = 0.
- R6: Port 0x102 reads back the full written value.
- R7: A read of port 0x91 returns 0x00, and writes to it change nothing.
- R8: Port 0x105 reads back the written value with bit 7 forced to 1.
- R9: Ports 0x94, 0x103, 0x104 and 0x190 store and return any 8-bit value independently.
- R10: The address is decoded on all 16 bits. Reads of unmapped addresses return 0xFF, and writes to them change no port and no output.
- R11: While `rd_i` is low, `rdata_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | I/O port address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, sampled on the clock edge |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Combinational read data |
| a20_en_o | output | 1 | Alternate A20 gate enable |
| cpu_rst_o | output | 1 | One-cycle soft CPU reset pulse |
| ser_en_o | output | 1 | Serial port enable |
| par_en_o | output | 1 | Parallel port enable |
| par_base_o | output | 2 | Parallel base select code |

## Verification
The hardest case to reach is back-to-back behaviour around the reset pulse. The pulse must drop one cycle after a write with bit 0 set, and it must not appear for a write with bit 0 clear. A write with bit 0 clear must still update the A20 output. The bench writes port 0x92 in a pattern that alternates bit 0 and bit 1 and samples the pulse on both cycles after each write. The reserved parallel select code is reached by sweeping every combination of enable bit and select field. Aliased addresses that match only the low byte of a port check that the decode uses all 16 bits.

// File: rtl/sysbrd_ctl_pkg.sv
package sysbrd_ctl_pkg;
  localparam int DATA_W = 8;
  localparam int NPORT  = 8;

  typedef enum logic [2:0] {
    P_ZERO = 3'd0, P_A20 = 3'd1, P_SCR0 = 3'd2, P_CFG = 3'd3,
    P_SCR1 = 3'd4, P_SCR2 = 3'd5, P_FRC = 3'd6, P_SCR3 = 3'd7
  } port_e;

  // field positions in the configuration port
  localparam int SER_BIT     = 2;
  localparam int PAR_EN_BIT  = 4;
  localparam int PAR_SEL_LSB = 5;
  localparam logic [1:0] PAR_SEL_RSVD = 2'd3;

  localparam logic [DATA_W-1:0] CFG_RST = 8'h10;
  localparam logic [DATA_W-1:0] FRC_SET = 8'h80;
  localparam logic [DATA_W-1:0] UNMAPPED = 8'hFF;

  typedef struct packed {
    logic [DATA_W-1:0] a20;
    logic [DATA_W-1:0] scr0;
    logic [DATA_W-1:0] cfg;
    logic [DATA_W-1:0] scr1;
    logic [DATA_W-1:0] scr2;
    logic [DATA_W-1:0] frc;
    logic [DATA_W-1:0] scr3;
  } regs_t;

  function automatic logic [15:0] port_addr(input int idx);
    case (idx)
      0:       port_addr = 16'h0091;
      1:       port_addr = 16'h0092;
      2:       port_addr = 16'h0094;
      3:       port_addr = 16'h0102;
      4:       port_addr = 16'h0103;
      5:       port_addr = 16'h0104;
      6:       port_addr = 16'h0105;
      default: port_addr = 16'h0190;
    endcase
  endfunction
endpackage

// File: rtl/sysbrd_port_dec.sv
module sysbrd_port_dec
  import sysbrd_ctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NPORT-1:0]  hit_o
);
  for (genvar g = 0; g < NPORT; g++) begin : g_hit
    assign hit_o[g] = (addr_i == ADDR_W'(port_addr(g)));
  end
endmodule

// File: rtl/sysbrd_ctl_regs.sv
module sysbrd_ctl_regs
  import sysbrd_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [NPORT-1:0]  hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output regs_t             regs_o,
  output logic              cpu_rst_o
);
  regs_t regs_q;
  logic  rst_pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q      <= '0;
      regs_q.cfg  <= CFG_RST;
      rst_pulse_q <= 1'b0;
    end else begin
      rst_pulse_q <= wr_i && hit_i[P_A20] && wdata_i[0];
      if (wr_i) begin
        if (hit_i[P_A20])  regs_q.a20  <= {wdata_i[DATA_W-1:1], 1'b0}; // reset bit self-clears
        if (hit_i[P_SCR0]) regs_q.scr0 <= wdata_i;
        if (hit_i[P_CFG])  regs_q.cfg  <= wdata_i;
        if (hit_i[P_SCR1]) regs_q.scr1 <= wdata_i;
        if (hit_i[P_SCR2]) regs_q.scr2 <= wdata_i;
        if (hit_i[P_FRC])  regs_q.frc  <= wdata_i;
        if (hit_i[P_SCR3]) regs_q.scr3 <= wdata_i;
      end
    end
  end

  assign regs_o    = regs_q;
  assign cpu_rst_o = rst_pulse_q;
endmodule

// File: rtl/sysbrd_cfg_dec.sv
module sysbrd_cfg_dec
  import sysbrd_ctl_pkg::*;
(
  input  logic [DATA_W-1:0] cfg_i,
  output logic              ser_en_o,
  output logic              par_en_o,
  output logic [1:0]        par_base_o
);
  logic [1:0] sel;
  assign sel        = cfg_i[PAR_SEL_LSB +: 2];
  assign ser_en_o   = cfg_i[SER_BIT];
  assign par_en_o   = cfg_i[PAR_EN_BIT] && (sel != PAR_SEL_RSVD);
  assign par_base_o = par_en_o ? sel : 2'd0;
endmodule

// File: rtl/sysbrd_ctl_ports.sv
module sysbrd_ctl_ports
  import sysbrd_ctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [7:0]        rdata_o,
  output logic              a20_en_o,
  output logic              cpu_rst_o,
  output logic              ser_en_o,
  output logic              par_en_o,
  output logic [1:0]        par_base_o
);
  logic [NPORT-1:0]  hit;
  regs_t             regs;
  logic [DATA_W-1:0] rd_mux;

  sysbrd_port_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  sysbrd_ctl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .hit_i     (hit),
    .wdata_i   (wdata_i),
    .regs_o    (regs),
    .cpu_rst_o (cpu_rst_o)
  );

  sysbrd_cfg_dec u_cfg (
    .cfg_i      (regs.cfg),
    .ser_en_o   (ser_en_o),
    .par_en_o   (par_en_o),
    .par_base_o (par_base_o)
  );

  assign a20_en_o = regs.a20[1];

  always_comb begin
    rd_mux = UNMAPPED;
    if      (hit[P_ZERO]) rd_mux = '0;
    else if (hit[P_A20])  rd_mux = regs.a20;
    else if (hit[P_SCR0]) rd_mux = regs.scr0;
    else if (hit[P_CFG])  rd_mux = regs.cfg;
    else if (hit[P_SCR1]) rd_mux = regs.scr1;
    else if (hit[P_SCR2]) rd_mux = regs.scr2;
    else if (hit[P_FRC])  rd_mux = regs.frc | FRC_SET;
    else if (hit[P_SCR3]) rd_mux = regs.scr3;
  end

  assign rdata_o = rd_i ? rd_mux : '0;
endmodule

// File: rtl/sysbrd_ctl_ports_chk.sv
module sysbrd_ctl_ports_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [7:0]        rdata_o,
  input logic              a20_en_o,
  input logic              cpu_rst_o,
  input logic              ser_en_o,
  input logic              par_en_o,
  input logic [1:0]        par_base_o
);
  logic wr_a20, wr_cfg;
  assign wr_a20 = wr_i && (addr_i == ADDR_W'(16'h0092));
  assign wr_cfg = wr_i && (addr_i == ADDR_W'(16'h0102));

  assert_a20_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_a20 |=> (a20_en_o == $past(wdata_i[1])));
  assert_a20_rd_bit0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(16'h0092)) |-> !rdata_o[0]);
  assert_rst_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_a20 && wdata_i[0]) |=> cpu_rst_o);
  assert_rst_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_a20 && wdata_i[0]) |=> !cpu_rst_o);
  assert_ser_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cfg |=> (ser_en_o == $past(wdata_i[2])));
  assert_par_no_rsvd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_en_o |-> (par_base_o != 2'd3));
  assert_par_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_en_o |-> (par_base_o == 2'd0));
  assert_zero_port_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(16'h0091)) |-> (rdata_o == 8'h00));
  assert_frc_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(16'h0105)) |-> rdata_o[7]);
  assert_rd_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == 8'h00));
endmodule

bind sysbrd_ctl_ports sysbrd_ctl_ports_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .rdata_o    (rdata_o),
  .a20_en_o   (a20_en_o),
  .cpu_rst_o  (cpu_rst_o),
  .ser_en_o   (ser_en_o),
  .par_en_o   (par_en_o),
  .par_base_o (par_base_o)
);

// File: tb/sysbrd_ctl_ports_tb_top.sv
module sysbrd_ctl_ports_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  rdata;
  logic        a20_en, cpu_rst, ser_en, par_en;
  logic [1:0]  par_base;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  sysbrd_ctl_ports dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .a20_en_o(a20_en),
    .cpu_rst_o(cpu_rst), .ser_en_o(ser_en), .par_en_o(par_en),
    .par_base_o(par_base)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write occupies one cycle; returns at the negedge after the capturing edge
  task automatic wr_port(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_port(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 a20", {7'd0, a20_en}, 8'd0);
    chk("R1 cpu_rst", {7'd0, cpu_rst}, 8'd0);
    chk("R1 ser_en", {7'd0, ser_en}, 8'd0);
    chk("R1 par_en", {7'd0, par_en}, 8'd1);
    chk("R1 par_base", {6'd0, par_base}, 8'd0);
    rd_port(16'h0094, d); chk("R1 0x94", d, 8'h00);
    rd_port(16'h0190, d); chk("R1 0x190", d, 8'h00);
    rd_port(16'h0102, d); chk("R1 0x102", d, 8'h10);
    rd_port(16'h0105, d); chk("R1 0x105", d, 8'h80);
  endtask

  task automatic t_a20_reset;
    logic [7:0] d;
    wr_port(16'h0092, 8'h03);
    chk("R3 pulse high", {7'd0, cpu_rst}, 8'd1);
    chk("R2 a20 set", {7'd0, a20_en}, 8'd1);
    @(negedge clk);
    chk("R3 pulse one cycle", {7'd0, cpu_rst}, 8'd0);
    rd_port(16'h0092, d); chk("R2 rd bit0 clear", d, 8'h02);
    wr_port(16'h0092, 8'hA0);
    chk("R3 no pulse", {7'd0, cpu_rst}, 8'd0);
    chk("R2 a20 clear", {7'd0, a20_en}, 8'd0);
    rd_port(16'h0092, d); chk("R2 readback", d, 8'hA0);
    wr_port(16'h0092, 8'h01);
    chk("R3 pulse again", {7'd0, cpu_rst}, 8'd1);
    chk("R2 a20 off", {7'd0, a20_en}, 8'd0);
    @(negedge clk);
    chk("R3 pulse drop", {7'd0, cpu_rst}, 8'd0);
  endtask

  task automatic t_cfg;
    logic [7:0] d;
    for (int en = 0; en < 2; en++) begin
      for (int sel = 0; sel < 4; sel++) begin
        logic [7:0] v;
        logic       exp_en;
        v = {1'b0, 2'(sel), 1'(en), 1'b0, 1'(sel[0]), 2'b01};
        exp_en = (en == 1) && (sel != 3);
        wr_port(16'h0102, v);
        chk("R5 par_en", {7'd0, par_en}, {7'd0, exp_en});
        chk("R5 par_base", {6'd0, par_base}, exp_en ? 8'(sel) : 8'd0);
        chk("R4 ser_en", {7'd0, ser_en}, {7'd0, v[2]});
        rd_port(16'h0102, d); chk("R6 readback", d, v);
      end
    end
  endtask

  task automatic t_fixed;
    logic [7:0] d;
    wr_port(16'h0091, 8'h5A);
    rd_port(16'h0091, d); chk("R7 zero port", d, 8'h00);
    wr_port(16'h0105, 8'h12);
    rd_port(16'h0105, d); chk("R8 forced bit", d, 8'h92);
    wr_port(16'h0105, 8'hC3);
    rd_port(16'h0105, d); chk("R8 set already", d, 8'hC3);
  endtask

  task automatic t_scratch;
    logic [7:0] d;
    wr_port(16'h0094, 8'h11);
    wr_port(16'h0103, 8'h22);
    wr_port(16'h0104, 8'h33);
    wr_port(16'h0190, 8'hFF);
    rd_port(16'h0094, d); chk("R9 0x94", d, 8'h11);
    rd_port(16'h0103, d); chk("R9 0x103", d, 8'h22);
    rd_port(16'h0104, d); chk("R9 0x104", d, 8'h33);
    rd_port(16'h0190, d); chk("R9 0x190", d, 8'hFF);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    wr_port(16'h0102, 8'h14);
    wr_port(16'h1094, 8'hEE);
    wr_port(16'h8102, 8'h00);
    wr_port(16'h0093, 8'h00);
    rd_port(16'h0094, d); chk("R10 alias no write", d, 8'h11);
    rd_port(16'h0102, d); chk("R10 cfg kept", d, 8'h14);
    chk("R10 ser kept", {7'd0, ser_en}, 8'd1);
    chk("R10 par kept", {7'd0, par_en}, 8'd1);
    rd_port(16'h1094, d); chk("R10 alias read", d, 8'hFF);
    rd_port(16'h0093, d); chk("R10 gap read", d, 8'hFF);
  endtask

  task automatic t_rd_idle;
    @(negedge clk);
    addr = 16'h0105; rd = 1'b0;
    #1 chk("R11 idle", rdata, 8'h00);
    addr = 16'h0200;
    #1 chk("R11 idle unmapped", rdata, 8'h00);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_a20_reset();
    t_cfg();
    t_fixed();
    t_scratch();
    t_unmapped();
    t_rd_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule